// File: doc/BRIEF.md
# ADC Histogram Parameter Accumulator

This block is the arithmetic back end of a built-in converter test that feeds a slow linear ramp into an ADC and counts how often each output code appears. A sequencer outside the block compares the converter output with one reference code at a time and sends a hit strobe for every matching sample. It also sends a step-end strobe when it moves to the next reference code. From these strobes a single saturating signed up/down accumulator forms offset, gain error, differential nonlinearity (DNL) and integral nonlinearity (INL). Each result is a signed fixed-point word.

A ramp makes the ideal histogram flat, so one ideal count per code, 2^P, covers every code. The gain window spans 2^Z codes. Every normalisation is therefore an arithmetic right shift, and no divider is needed. Before each run the sequencer selects a phase and pulses clear. The block then reports once per phase for offset and gain, and once per step for DNL and INL. An optional comparator flags any result whose raw count deviation exceeds a limit applied at an input.

Top module: `adc_hist_param_acc`

## Requirements
- R1: After reset, res_valid and over_limit are 0 and result is 0. A clear pulse restarts the step count of the selected phase, reloads the accumulator and empties the INL running sum, so only hits after the clear contribute.
- R2: Offset phase (phase = 0) has two steps. Hits in the first step count down and hits in the second step count up. A single report follows the second step-end only, with raw value H_second − H_first scaled by a right shift of P+1.
- R3: Gain phase (phase = 1) reports only after the 2^Z-th step-end. Its raw value is the total hit count over all those steps minus 2^(P+Z), scaled by a right shift of P+Z.
- R4: DNL phase (phase = 2) reports after every step. The raw value is that step's hit count minus 2^P, scaled by a right shift of P.
- R5: INL phase (phase = 3) reports after every step. The raw value is the saturating running sum of (hits − 2^P) over all steps since the last clear, scaled by a right shift of P.
- R6: A hit in the same cycle as step_end is counted in the step that is ending.
- R7: The accumulator saturates at its signed limits, +(2^(ACC_W−1)−1) and −2^(ACC_W−1), and never wraps.
- R8: over_limit is asserted together with res_valid exactly when the magnitude of the raw value exceeds the limit input. It is otherwise 0.
- R9: res_valid is a one-cycle pulse in the cycle after the clock edge that samples a reporting step_end. result holds its value between reports.
- R10: result is signed two's complement with FRAC_W fractional bits, equal to floor(raw · 2^FRAC_W / 2^shift).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart the selected phase |
| phase | input | 2 | 0 offset, 1 gain, 2 DNL, 3 INL |
| hit | input | 1 | Converter output matched the reference code this cycle |
| step_end | input | 1 | Current reference code finished |
| limit | input | RAW_W | Magnitude bound on the raw count deviation |
| result | output | RAW_W+FRAC_W | Scaled signed parameter value |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| over_limit | output | 1 | Raw magnitude exceeded limit on this report |

## Verification
The offset phase is driven with two steps of unequal random hit counts, in both orders, so that the sign of the difference and the down-then-up direction are exposed. Gain runs use random counts near the ideal across all 2^Z steps, so a report after any step other than the last, or a wrong shift, shows up. DNL and INL runs use random per-step counts on both sides of 2^P: DNL shows that the accumulator reloads every step, and INL shows that the running sum is carried between steps. Directed cases cover a hit on the step-end cycle, an overflowing step that must clamp, limits of zero and maximum, and a clear partway through a phase.

// File: rtl/hist_acc_pkg.sv
package hist_acc_pkg;
  typedef enum logic [1:0] {
    PH_OFFSET = 2'd0,
    PH_GAIN   = 2'd1,
    PH_DNL    = 2'd2,
    PH_INL    = 2'd3
  } phase_e;

  // Normalising right shift for each phase
  function automatic int shift_of(phase_e ph, int p, int z);
    case (ph)
      PH_OFFSET: return p + 1;
      PH_GAIN:   return p + z;
      default:   return p;
    endcase
  endfunction
endpackage

// File: rtl/hist_step_ctrl.sv
module hist_step_ctrl
  import hist_acc_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int GAIN_STEPS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  phase_e           phase,
  input  logic             step_end,
  output logic [CNT_W-1:0] step_idx,
  output logic             count_up,
  output logic             report
);
  logic last_step;

  always_comb begin
    case (phase)
      PH_OFFSET: last_step = (step_idx == CNT_W'(1));
      PH_GAIN:   last_step = (step_idx == CNT_W'(GAIN_STEPS - 1));
      default:   last_step = 1'b1;
    endcase
  end

  assign report   = step_end && last_step && !clear;
  assign count_up = !(phase == PH_OFFSET && step_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               step_idx <= '0;
    else if (clear || report) step_idx <= '0;
    else if (step_end)        step_idx <= step_idx + CNT_W'(1);
  end
endmodule

// File: rtl/hist_updown_acc.sv
module hist_updown_acc #(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic                up,
  input  logic                reload,
  input  logic signed [W-1:0] reload_val,
  output logic signed [W-1:0] acc_q,
  output logic signed [W-1:0] acc_next
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sat_step(logic signed [W-1:0] v, logic inc);
    if (inc) return (v == MAXV) ? v : v + W'(1);
    else     return (v == MINV) ? v : v - W'(1);
  endfunction

  assign acc_next = hit ? sat_step(acc_q, up) : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (reload) acc_q <= reload_val;
    else             acc_q <= acc_next;
  end
endmodule

// File: rtl/hist_result_stage.sv
module hist_result_stage
  import hist_acc_pkg::*;
#(
  parameter int ACC_W     = 10,
  parameter int RAW_W     = 12,
  parameter int FRAC_W    = 8,
  parameter int P         = 5,
  parameter int Z         = 4,
  parameter int HAS_LIMIT = 1,
  localparam int RES_W    = RAW_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    report,
  input  phase_e                  phase,
  input  logic signed [ACC_W-1:0] acc_next,
  input  logic [RAW_W-1:0]        limit,
  output logic signed [RES_W-1:0] result,
  output logic                    res_valid,
  output logic                    over_limit
);
  localparam logic signed [RAW_W-1:0] RMAX = {1'b0, {(RAW_W-1){1'b1}}};
  localparam logic signed [RAW_W-1:0] RMIN = {1'b1, {(RAW_W-1){1'b0}}};

  logic signed [RAW_W-1:0] inl_q, inl_sum, raw_acc, raw;
  logic [RAW_W-1:0]        raw_mag;
  logic                    over_d;

  function automatic logic signed [RAW_W-1:0] sat_add(logic signed [RAW_W-1:0] a,
                                                      logic signed [RAW_W-1:0] b);
    logic signed [RAW_W:0] s;
    s = {a[RAW_W-1], a} + {b[RAW_W-1], b};
    if (s[RAW_W] != s[RAW_W-1]) return s[RAW_W] ? RMIN : RMAX;
    return s[RAW_W-1:0];
  endfunction

  // raw * 2^FRAC_W, arithmetic shift keeps the sign
  function automatic logic signed [RES_W-1:0] scale(logic signed [RAW_W-1:0] v, int sh);
    logic signed [RES_W-1:0] w;
    w = {v, {FRAC_W{1'b0}}};
    return w >>> sh;
  endfunction

  assign raw_acc = {{(RAW_W-ACC_W){acc_next[ACC_W-1]}}, acc_next};
  assign inl_sum = sat_add(inl_q, raw_acc);
  assign raw     = (phase == PH_INL) ? inl_sum : raw_acc;
  assign raw_mag = raw[RAW_W-1] ? (~raw + RAW_W'(1)) : raw;

  generate
    if (HAS_LIMIT != 0) begin : g_limit
      assign over_d = (raw_mag > limit);
    end else begin : g_nolimit
      assign over_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inl_q      <= '0;
      result     <= '0;
      res_valid  <= 1'b0;
      over_limit <= 1'b0;
    end else begin
      res_valid  <= report;
      over_limit <= report && over_d;
      if (report) result <= scale(raw, shift_of(phase, P, Z));
      if (clear)                            inl_q <= '0;
      else if (report && phase == PH_INL)   inl_q <= inl_sum;
    end
  end
endmodule

// File: rtl/adc_hist_param_acc.sv
module adc_hist_param_acc
  import hist_acc_pkg::*;
#(
  parameter int P         = 5,
  parameter int Z         = 4,
  parameter int ACC_W     = 10,
  parameter int FRAC_W    = 8,
  parameter int HAS_LIMIT = 1,
  localparam int RAW_W    = ACC_W + 2,
  localparam int RES_W    = RAW_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic [1:0]              phase,
  input  logic                    hit,
  input  logic                    step_end,
  input  logic [RAW_W-1:0]        limit,
  output logic signed [RES_W-1:0] result,
  output logic                    res_valid,
  output logic                    over_limit
);
  localparam int CNT_W      = Z + 1;
  localparam int GAIN_STEPS = 1 << Z;
  localparam logic signed [ACC_W-1:0] PRE_GAIN = ACC_W'(-(1 << (P + Z)));
  localparam logic signed [ACC_W-1:0] PRE_CODE = ACC_W'(-(1 << P));

  phase_e                  ph;
  logic [CNT_W-1:0]        step_idx;
  logic                    count_up, report, reload;
  logic signed [ACC_W-1:0] acc_q, acc_next, preload;

  assign ph     = phase_e'(phase);
  assign reload = clear || report;

  always_comb begin
    case (ph)
      PH_OFFSET: preload = '0;
      PH_GAIN:   preload = PRE_GAIN;
      default:   preload = PRE_CODE;
    endcase
  end

  hist_step_ctrl #(.CNT_W(CNT_W), .GAIN_STEPS(GAIN_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .phase(ph), .step_end(step_end),
    .step_idx(step_idx), .count_up(count_up), .report(report)
  );

  hist_updown_acc #(.W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .hit(hit), .up(count_up), .reload(reload),
    .reload_val(preload), .acc_q(acc_q), .acc_next(acc_next)
  );

  hist_result_stage #(
    .ACC_W(ACC_W), .RAW_W(RAW_W), .FRAC_W(FRAC_W), .P(P), .Z(Z), .HAS_LIMIT(HAS_LIMIT)
  ) u_res (
    .clk(clk), .rst_n(rst_n), .clear(clear), .report(report), .phase(ph),
    .acc_next(acc_next), .limit(limit), .result(result), .res_valid(res_valid),
    .over_limit(over_limit)
  );
endmodule

// File: rtl/hist_acc_checker.sv
module hist_acc_checker #(
  parameter int ACC_W      = 10,
  parameter int CNT_W      = 5,
  parameter int GAIN_STEPS = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clear,
  input logic                    step_end,
  input logic [1:0]              phase,
  input logic                    hit,
  input logic                    count_up,
  input logic                    report,
  input logic [CNT_W-1:0]        step_idx,
  input logic signed [ACC_W-1:0] acc_q,
  input logic                    res_valid,
  input logic                    over_limit
);
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  assert_valid_after_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(step_end) && !$past(clear)));

  assert_clear_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !res_valid);

  assert_offset_two_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(phase) == 2'd0) |-> $past(step_idx) == CNT_W'(1));

  assert_gain_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(phase) == 2'd1) |-> $past(step_idx) == CNT_W'(GAIN_STEPS - 1));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == MAXV && hit && count_up && !clear && !report) |=> acc_q == MAXV);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == MINV && hit && !count_up && !clear && !report) |=> acc_q == MINV);

  assert_flag_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit |-> res_valid);
endmodule

bind adc_hist_param_acc hist_acc_checker #(
  .ACC_W(ACC_W), .CNT_W(CNT_W), .GAIN_STEPS(GAIN_STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .step_end(step_end), .phase(phase),
  .hit(hit), .count_up(count_up), .report(report), .step_idx(step_idx),
  .acc_q(acc_q), .res_valid(res_valid), .over_limit(over_limit)
);

// File: tb/adc_hist_param_acc_test.sv
module adc_hist_param_acc_test;
  localparam int P = 5, Z = 4, ACC_W = 10, FRAC_W = 8;
  localparam int RAW_W = ACC_W + 2, RES_W = RAW_W + FRAC_W;
  localparam int HID = 1 << P, STEPS = 1 << Z;

  logic clk = 0, rst_n = 0, clear = 0, hit = 0, step_end = 0;
  logic [1:0] phase = 0;
  logic [RAW_W-1:0] limit = '1;
  logic signed [RES_W-1:0] result;
  logic res_valid, over_limit;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  adc_hist_param_acc #(.P(P), .Z(Z), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .HAS_LIMIT(1)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .phase(phase), .hit(hit),
    .step_end(step_end), .limit(limit), .result(result), .res_valid(res_valid),
    .over_limit(over_limit)
  );

  function automatic int floor_div(int v, int d);
    if (v >= 0) return v / d;
    return -((-v + d - 1) / d);
  endfunction

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic h, logic e);
    @(negedge clk);
    hit = h; step_end = e;
  endtask

  task automatic do_clear(logic [1:0] ph);
    @(negedge clk);
    phase = ph; clear = 1; hit = 0; step_end = 0;
    @(negedge clk);
    clear = 0;
  endtask

  // n hits with random idle gaps, then step_end (carrying the last hit if overlap)
  task automatic run_step(int n, bit overlap);
    int body = overlap ? n - 1 : n;
    for (int k = 0; k < body; k++) begin
      if ($urandom % 3 == 0) cyc(0, 0);
      cyc(1, 0);
    end
    cyc(overlap, 1);
    @(negedge clk);
    hit = 0; step_end = 0;
  endtask

  task automatic expect_report(string req, int raw, int sh);
    int mag = (raw < 0) ? -raw : raw;
    check(req, int'(res_valid), 1);
    check(req, int'(result), floor_div(raw * (1 << FRAC_W), 1 << sh));
    check("R8", int'(over_limit), int'(mag > int'(limit)));
  endtask

  task automatic expect_quiet(string req);
    check(req, int'(res_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL R9: watchdog expired, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int h1, h2, sum, hs, inl;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(res_valid), 0);
    check("R1", int'(result), 0);
    check("R1", int'(over_limit), 0);
    rst_n = 1;

    // R2 / R10: offset, both orders of counts
    limit = RAW_W'(5);
    for (int it = 0; it < 4; it++) begin
      do_clear(2'd0);
      h1 = 10 + int'($urandom % 30);
      h2 = 10 + int'($urandom % 30);
      run_step(h1, 0);
      expect_quiet("R2");
      run_step(h2, 0);
      expect_report("R2", h2 - h1, P + 1);
      @(negedge clk);
      expect_quiet("R9");
    end

    // R3: gain over 2^Z steps
    limit = RAW_W'(20);
    for (int it = 0; it < 2; it++) begin
      do_clear(2'd1);
      sum = 0;
      for (int s = 0; s < STEPS; s++) begin
        hs = 26 + int'($urandom % 12);
        sum += hs;
        run_step(hs, 0);
        if (s < STEPS - 1) expect_quiet("R3");
      end
      expect_report("R3", sum - STEPS * HID, P + Z);
    end

    // R4: DNL per step
    limit = RAW_W'(6);
    do_clear(2'd2);
    for (int s = 0; s < 8; s++) begin
      hs = 20 + int'($urandom % 25);
      run_step(hs, 0);
      expect_report("R4", hs - HID, P);
    end

    // R5: INL running sum, kept across steps
    do_clear(2'd3);
    inl = 0;
    for (int s = 0; s < 10; s++) begin
      hs = 22 + int'($urandom % 20);
      inl = clampi(inl + hs - HID, -2048, 2047);
      run_step(hs, 0);
      expect_report("R5", inl, P);
    end
    // R1: clear empties the INL sum
    do_clear(2'd3);
    run_step(35, 0);
    expect_report("R1", 35 - HID, P);

    // R6: hit on the step_end cycle belongs to the ending step
    do_clear(2'd2);
    run_step(40, 1);
    expect_report("R6", 40 - HID, P);
    do_clear(2'd0);
    run_step(7, 1);
    run_step(12, 1);
    expect_report("R6", 5, P + 1);

    // R7: saturation at the top of the accumulator
    limit = '1;
    do_clear(2'd2);
    run_step(600, 0);
    expect_report("R7", (1 << (ACC_W - 1)) - 1, P);
    run_step(HID, 0);
    expect_report("R7", 0, P);

    // R8: limit edges
    limit = '0;
    do_clear(2'd2);
    run_step(HID, 0);
    expect_report("R8", 0, P);
    run_step(HID + 1, 0);
    expect_report("R8", 1, P);
    limit = '1;
    run_step(1, 0);
    expect_report("R8", 1 - HID, P);

    // R1: clear partway through gain restarts the step count
    do_clear(2'd1);
    for (int s = 0; s < 5; s++) run_step(30, 0);
    do_clear(2'd1);
    sum = 0;
    for (int s = 0; s < STEPS; s++) begin
      hs = 28 + int'($urandom % 8);
      sum += hs;
      run_step(hs, 0);
      if (s < STEPS - 1) expect_quiet("R1");
    end
    expect_report("R1", sum - STEPS * HID, P + Z);

    // R9: result holds after the pulse
    h1 = int'(result);
    repeat (3) @(negedge clk);
    expect_quiet("R9");
    check("R9", int'(result), h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule